// File: doc/BRIEF.md
# Program/Data Address Mapper

This block decodes addresses for a core whose program and data memories share one linear view. It takes a program-fetch address and a data-space address and decides, for each, which physical memory answers. The targets are one of four 16kWord user program pages, the utility ROM, or the data RAM. It also returns the offset within that target. A no-target flag is raised when nothing answers. The decode itself is combinational. A small configuration register holds three settings, each loaded when `cfg_we` is high at a rising clock edge: the upper-program enable, the word/byte data mode and the two code-window select bits.

The execution source is the target of the current fetch address. Code running from the utility ROM sees the selected program page or pages through the upper half of data space. Code running from data RAM sees them through the lower half. Code running from user pages sees no window. In word mode the window covers two pages (32kWords). In byte mode it covers one page, addressed in bytes. Setting the upper-program enable places pages 2 and 3 in the upper half of program space. In that mode the utility ROM and data-as-code are removed from program space.

Top module: `pvn_addr_map`

## Requirements
- R1: After reset the configuration is upper-program off, word mode (mode bit 1) and window select 00. The configuration changes only at a rising clock edge with `cfg_we` high; a pulse of `cfg_we` low leaves every decode unchanged.
- R2: With upper-program off, a fetch address below 8000h selects a user page (sel 001), page = address bits [15:14], offset = address bits [13:0].
- R3: With upper-program off, a fetch address from 8000h up to A000h-1 selects the utility ROM (sel 010) with offset = address - 8000h.
- R4: With upper-program off, a fetch address from A000h up selects data RAM (sel 100) with offset = address - A000h if that offset is below the RAM size (default 1000h words); otherwise no target.
- R5: With upper-program on, every fetch address selects a user page, page = bits [15:14], offset = bits [13:0]; the utility ROM and data RAM are never selected by a fetch.
- R6: When the fetch selects a user page or no target, no program page is visible in data space: data addresses go to data RAM (offset = address) when in range, else no target.
- R7: When the fetch selects the utility ROM, data addresses with bit 15 set hit the program-page window; those with bit 15 clear go to data RAM.
- R8: When the fetch selects data RAM, data addresses with bit 15 clear hit the program-page window; those with bit 15 set go to data RAM if in range.
- R9: In byte mode (mode bit 0) a window hit selects page = window select bits, word offset = data address bits [14:1].
- R10: In word mode a window hit selects page = {select bit 1, data address bit 14}, offset = data address bits [13:0].
- R11: Data RAM range is address < RAM size in word mode and < twice the RAM size in byte mode; an out-of-range, non-window data address gives no target with page and offset zero.
- R12: On each side exactly one of the three select bits is set, or none is and the no-target flag is high; page is zero unless a user page is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load configuration at the next rising edge |
| cfg_upa | input | 1 | Upper-program enable to load |
| cfg_wbs | input | 1 | Data mode to load: 1 word, 0 byte |
| cfg_cda | input | 2 | Code-window page select to load |
| fetch_addr | input | 16 | Program-fetch word address |
| data_addr | input | 16 | Data-space address (word or byte units per mode) |
| f_sel | output | 3 | Fetch target: 001 page, 010 utility ROM, 100 data RAM |
| f_page | output | 2 | Fetch user page number |
| f_off | output | 16 | Fetch word offset within target |
| f_none | output | 1 | Fetch address has no target |
| d_sel | output | 3 | Data target, same encoding as f_sel |
| d_page | output | 2 | Data-side program page number |
| d_off | output | 16 | Data offset within target |
| d_none | output | 1 | Data address has no target |

## Verification
The assertions take for granted that every input is driven to known values and that the parameters keep the address width exactly two bits wider than a page offset, with the ROM base below the data-as-code base. They also assume that the RAM size fits inside the lower half of data space. The bench keeps to these by driving every input from time zero, using the default parameters and changing inputs only between clock edges. Its vectors visit each region boundary in both data modes and with all three execution sources.

// File: rtl/pvn_pkg.sv
package pvn_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'b000,
    TGT_PAGE = 3'b001,
    TGT_UROM = 3'b010,
    TGT_RAM  = 3'b100
  } tgt_e;

  typedef struct packed {
    logic       upa;
    logic       wbs;
    logic [1:0] cda;
  } cfg_t;

  localparam cfg_t CFG_RST = '{upa: 1'b0, wbs: 1'b1, cda: 2'b00};
endpackage

// File: rtl/pvn_cfg_reg.sv
module pvn_cfg_reg
  import pvn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  cfg_t d,
  output cfg_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= CFG_RST;
    else if (we) q <= d;
  end

  // R1: configuration holds without a write
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  // R1: a write takes the presented value
  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));
endmodule

// File: rtl/pvn_fetch_dec.sv
module pvn_fetch_dec
  import pvn_pkg::*;
#(
  parameter int AW = 16,
  parameter int PAGE_AW = 14,
  parameter logic [AW-1:0] UROM_BASE = 16'h8000,
  parameter logic [AW-1:0] DCODE_BASE = 16'hA000,
  parameter logic [AW-1:0] RAM_WORDS = 16'h1000
) (
  input  logic [AW-1:0]         addr,
  input  logic                  upa,
  output tgt_e                  sel,
  output logic [AW-PAGE_AW-1:0] page,
  output logic [AW-1:0]         off
);
  localparam int PG_W = AW - PAGE_AW;

  logic [AW-1:0] dc_off;
  assign dc_off = addr - DCODE_BASE;

  always_comb begin
    sel  = TGT_NONE;
    page = '0;
    off  = '0;
    if (upa || (addr < UROM_BASE)) begin
      sel  = TGT_PAGE;
      page = addr[AW-1:PAGE_AW];
      off  = {{PG_W{1'b0}}, addr[PAGE_AW-1:0]};
    end else if (addr < DCODE_BASE) begin
      sel = TGT_UROM;
      off = addr - UROM_BASE;
    end else if (dc_off < RAM_WORDS) begin
      sel = TGT_RAM;
      off = dc_off;
    end
  end

  always_comb begin
    assert_fetch_onehot_R12: assert ($onehot0(sel));
    if (upa) begin
      assert_fetch_upa_R5: assert (sel != TGT_UROM && sel != TGT_RAM);
    end
    if (sel == TGT_RAM) begin
      assert_fetch_ram_rng_R4: assert (off < RAM_WORDS && addr >= DCODE_BASE);
    end
    if (sel == TGT_UROM) begin
      assert_fetch_urom_rng_R3: assert (off < (DCODE_BASE - UROM_BASE) && !upa);
    end
  end
endmodule

// File: rtl/pvn_data_dec.sv
module pvn_data_dec
  import pvn_pkg::*;
#(
  parameter int AW = 16,
  parameter int PAGE_AW = 14,
  parameter logic [AW-1:0] RAM_WORDS = 16'h1000
) (
  input  logic [AW-1:0]         addr,
  input  tgt_e                  exec_src,
  input  logic                  wbs,
  input  logic [1:0]            cda,
  output tgt_e                  sel,
  output logic [AW-PAGE_AW-1:0] page,
  output logic [AW-1:0]         off
);
  localparam int PG_W = AW - PAGE_AW;
  localparam logic [AW:0] LIM_WORD = {1'b0, RAM_WORDS};
  localparam logic [AW:0] LIM_BYTE = {RAM_WORDS, 1'b0};

  logic win_hit;
  logic in_ram;

  always_comb begin
    win_hit = ((exec_src == TGT_UROM) && addr[AW-1]) ||
              ((exec_src == TGT_RAM) && !addr[AW-1]);
    in_ram  = wbs ? ({1'b0, addr} < LIM_WORD) : ({1'b0, addr} < LIM_BYTE);
  end

  always_comb begin
    sel  = TGT_NONE;
    page = '0;
    off  = '0;
    if (win_hit) begin
      sel = TGT_PAGE;
      if (wbs) begin
        page = {cda[1], addr[PAGE_AW]};
        off  = {{PG_W{1'b0}}, addr[PAGE_AW-1:0]};
      end else begin
        page = cda;
        off  = {{PG_W{1'b0}}, addr[PAGE_AW:1]};
      end
    end else if (in_ram) begin
      sel = TGT_RAM;
      off = addr;
    end
  end

  always_comb begin
    assert_data_onehot_R12: assert ($onehot0(sel));
    if (sel != TGT_PAGE) begin
      assert_data_page_zero_R12: assert (page == '0);
    end
    if (sel == TGT_PAGE && !wbs) begin
      assert_byte_page_R9: assert (page == cda);
    end
    if (sel == TGT_RAM && wbs) begin
      assert_word_ram_rng_R11: assert (off < RAM_WORDS);
    end
  end
endmodule

// File: rtl/pvn_addr_map.sv
module pvn_addr_map
  import pvn_pkg::*;
#(
  parameter int AW = 16,
  parameter int PAGE_AW = 14,
  parameter logic [AW-1:0] UROM_BASE = 16'h8000,
  parameter logic [AW-1:0] DCODE_BASE = 16'hA000,
  parameter logic [AW-1:0] RAM_WORDS = 16'h1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_upa,
  input  logic                  cfg_wbs,
  input  logic [1:0]            cfg_cda,
  input  logic [AW-1:0]         fetch_addr,
  input  logic [AW-1:0]         data_addr,
  output logic [2:0]            f_sel,
  output logic [AW-PAGE_AW-1:0] f_page,
  output logic [AW-1:0]         f_off,
  output logic                  f_none,
  output logic [2:0]            d_sel,
  output logic [AW-PAGE_AW-1:0] d_page,
  output logic [AW-1:0]         d_off,
  output logic                  d_none
);
  cfg_t cfg_d, cfg_q;
  tgt_e f_tgt, d_tgt;

  assign cfg_d = '{upa: cfg_upa, wbs: cfg_wbs, cda: cfg_cda};

  pvn_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .d(cfg_d), .q(cfg_q)
  );

  pvn_fetch_dec #(
    .AW(AW), .PAGE_AW(PAGE_AW), .UROM_BASE(UROM_BASE),
    .DCODE_BASE(DCODE_BASE), .RAM_WORDS(RAM_WORDS)
  ) u_fetch (
    .addr(fetch_addr), .upa(cfg_q.upa), .sel(f_tgt), .page(f_page), .off(f_off)
  );

  pvn_data_dec #(
    .AW(AW), .PAGE_AW(PAGE_AW), .RAM_WORDS(RAM_WORDS)
  ) u_data (
    .addr(data_addr), .exec_src(f_tgt), .wbs(cfg_q.wbs), .cda(cfg_q.cda),
    .sel(d_tgt), .page(d_page), .off(d_off)
  );

  assign f_sel  = f_tgt;
  assign d_sel  = d_tgt;
  assign f_none = (f_tgt == TGT_NONE);
  assign d_none = (d_tgt == TGT_NONE);

  always_comb begin
    if (f_tgt != TGT_UROM && f_tgt != TGT_RAM) begin
      assert_no_window_R6: assert (d_tgt != TGT_PAGE);
    end
    if (f_tgt == TGT_UROM && d_tgt == TGT_PAGE) begin
      assert_urom_upper_R7: assert (data_addr[AW-1]);
    end
    if (f_tgt == TGT_RAM && d_tgt == TGT_PAGE) begin
      assert_ram_lower_R8: assert (!data_addr[AW-1]);
    end
  end
endmodule

// File: tb/pvn_addr_map_tb.sv
module pvn_addr_map_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_upa = 1'b0, cfg_wbs = 1'b1;
  logic [1:0] cfg_cda = 2'd0;
  logic [15:0] fetch_addr = 16'h0, data_addr = 16'h0;
  logic [2:0] f_sel, d_sel;
  logic [1:0] f_page, d_page;
  logic [15:0] f_off, d_off;
  logic f_none, d_none;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pvn_addr_map dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_upa(cfg_upa),
    .cfg_wbs(cfg_wbs), .cfg_cda(cfg_cda), .fetch_addr(fetch_addr),
    .data_addr(data_addr), .f_sel(f_sel), .f_page(f_page), .f_off(f_off),
    .f_none(f_none), .d_sel(d_sel), .d_page(d_page), .d_off(d_off),
    .d_none(d_none)
  );

  // upa wbs cda fa da | fs fp fo | ds dp do | fetch tag, data tag
  localparam int VW = 86;
  localparam logic [VW-1:0] VECS [0:15] = '{
    {1'b0,1'b1,2'd0,16'h1234,16'h0010, 3'b001,2'd0,16'h1234, 3'b100,2'd0,16'h0010, 4'd2,4'd6},
    {1'b0,1'b1,2'd0,16'h4001,16'h0FFF, 3'b001,2'd1,16'h0001, 3'b100,2'd0,16'h0FFF, 4'd2,4'd6},
    {1'b0,1'b1,2'd0,16'h7FFF,16'h1000, 3'b001,2'd1,16'h3FFF, 3'b000,2'd0,16'h0000, 4'd2,4'd11},
    {1'b0,1'b1,2'd0,16'h8005,16'h8000, 3'b010,2'd0,16'h0005, 3'b001,2'd0,16'h0000, 4'd3,4'd10},
    {1'b0,1'b1,2'd2,16'h9FFF,16'hC123, 3'b010,2'd0,16'h1FFF, 3'b001,2'd3,16'h0123, 4'd3,4'd7},
    {1'b0,1'b1,2'd1,16'h9000,16'h0200, 3'b010,2'd0,16'h1000, 3'b100,2'd0,16'h0200, 4'd3,4'd7},
    {1'b0,1'b0,2'd3,16'h8000,16'h8003, 3'b010,2'd0,16'h0000, 3'b001,2'd3,16'h0001, 4'd3,4'd9},
    {1'b0,1'b0,2'd1,16'h8000,16'h1FFF, 3'b010,2'd0,16'h0000, 3'b100,2'd0,16'h1FFF, 4'd3,4'd11},
    {1'b0,1'b0,2'd1,16'h8000,16'h2000, 3'b010,2'd0,16'h0000, 3'b000,2'd0,16'h0000, 4'd3,4'd11},
    {1'b0,1'b1,2'd0,16'hA010,16'h4005, 3'b100,2'd0,16'h0010, 3'b001,2'd1,16'h0005, 4'd4,4'd8},
    {1'b0,1'b1,2'd2,16'hA000,16'h8100, 3'b100,2'd0,16'h0000, 3'b000,2'd0,16'h0000, 4'd4,4'd8},
    {1'b0,1'b0,2'd2,16'hAFFF,16'h7FFF, 3'b100,2'd0,16'h0FFF, 3'b001,2'd2,16'h3FFF, 4'd4,4'd9},
    {1'b0,1'b1,2'd0,16'hB000,16'h0004, 3'b000,2'd0,16'h0000, 3'b100,2'd0,16'h0004, 4'd4,4'd6},
    {1'b1,1'b1,2'd0,16'h8005,16'h8000, 3'b001,2'd2,16'h0005, 3'b000,2'd0,16'h0000, 4'd5,4'd11},
    {1'b1,1'b0,2'd3,16'hFFFF,16'h0003, 3'b001,2'd3,16'h3FFF, 3'b100,2'd0,16'h0003, 4'd5,4'd6},
    {1'b1,1'b1,2'd0,16'hA010,16'h0100, 3'b001,2'd2,16'h2010, 3'b100,2'd0,16'h0100, 4'd5,4'd6}
  };

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic upa, input logic wbs, input logic [1:0] cda);
    @(negedge clk);
    cfg_we = 1'b1; cfg_upa = upa; cfg_wbs = wbs; cfg_cda = cda;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic check_outputs(input string ft, input string dt,
                               input logic [2:0] fs, input logic [1:0] fp, input logic [15:0] fo,
                               input logic [2:0] ds, input logic [1:0] dp, input logic [15:0] dd);
    chk(ft, "f_sel", {13'd0, f_sel}, {13'd0, fs});
    chk(ft, "f_page", {14'd0, f_page}, {14'd0, fp});
    chk(ft, "f_off", f_off, fo);
    chk(dt, "d_sel", {13'd0, d_sel}, {13'd0, ds});
    chk(dt, "d_page", {14'd0, d_page}, {14'd0, dp});
    chk(dt, "d_off", d_off, dd);
    chk("R12", "f_none", {15'd0, f_none}, {15'd0, fs == 3'b000});
    chk("R12", "d_none", {15'd0, d_none}, {15'd0, ds == 3'b000});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset configuration: ROM window visible, word mode, select 00
    fetch_addr = 16'h8000; data_addr = 16'h8002;
    #2 check_outputs("R1", "R1", 3'b010, 2'd0, 16'h0000, 3'b001, 2'd0, 16'h0002);
    // R1: inputs changed with write enable low have no effect
    @(negedge clk);
    cfg_upa = 1'b1; cfg_wbs = 1'b0; cfg_cda = 2'd3;
    @(posedge clk);
    #2 check_outputs("R1", "R1", 3'b010, 2'd0, 16'h0000, 3'b001, 2'd0, 16'h0002);

    for (int i = 0; i < 16; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      write_cfg(v[85], v[84], v[83:82]);
      fetch_addr = v[81:66];
      data_addr  = v[65:50];
      #2 check_outputs(tag(v[7:4]), tag(v[3:0]),
                       v[49:47], v[46:45], v[44:29], v[28:26], v[25:24], v[23:8]);
    end

    // R1: a write takes effect only at the edge
    write_cfg(1'b0, 1'b1, 2'd0);
    fetch_addr = 16'h8000; data_addr = 16'hC000;
    @(negedge clk);
    cfg_we = 1'b1; cfg_upa = 1'b1; cfg_wbs = 1'b1; cfg_cda = 2'd2;
    #1 check_outputs("R1", "R10", 3'b010, 2'd0, 16'h0000, 3'b001, 2'd1, 16'h0000);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    #2 check_outputs("R5", "R11", 3'b001, 2'd2, 16'h0000, 3'b000, 2'd0, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule